// File: doc/BRIEF.md
# Cascadable Eight-Input Interrupt Controller

This block collects eight edge-triggered interrupt inputs, holds them as pending requests, and picks one by priority for a processor. A small register port with two addresses is used for access. The command address carries the setup word that starts configuration, the end-of-interrupt and priority-setting commands, and the selection of which status register a read returns. The data address carries the remaining configuration words and then the per-input mask register.

After configuration the controller raises `int_out` when an unmasked request outranks everything in service. On a one-cycle `inta` pulse it moves the winning request into the in-service register and returns an 8-bit vector made from the configured base and the input number. One controller can act as the master of a cascade, with slaves hanging off selected inputs. Another can act as a slave that answers only when the 3-bit cascade code matches its own identity. A nested mode lets a slave behind a master raise further interrupts while its cascade input is already in service.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset all mask bits read 1, the request and in-service registers are 0, input 0 has the top priority, and `int_out` stays low until configuration finishes.
- R2: A command-address write with bit 4 set starts configuration, with bit 0 meaning a mode word follows and bit 1 meaning single (no cascade word). The next data-address writes are taken as the vector base (bits 7:3), then the cascade word unless single, then the mode word if asked. A single controller treats no input as a cascade input.
- R3: Outside configuration, data-address writes and reads access the mask register, where a 1 masks that input. A masked request never raises `int_out`, and unmasking a held request raises it.
- R4: A rising edge on an input sets its request bit, and a level held high does not set it again. After command 0x0A, command-address reads return the request register. After 0x0B, they return the in-service register.
- R5: `int_out` is high when an unmasked request ranks above every in-service bit. With fixed priority, input 0 ranks highest.
- R6: The command 0xC0 | n (bits 7:5 = 110) makes input n the lowest priority and input n+1 the highest, so n=1 gives the order 2,3,4,5,6,7,0,1.
- R7: The command 0x20 (bits 7:5 = 001) clears only the highest-priority set bit of the in-service register.
- R8: On `inta`, the winning request moves from the request to the in-service register. In the next cycle `vec_valid` pulses with `vec_out` = {base, input number}.
- R9: A master whose cascade word has bit i set answers an acknowledge won by input i with `cas_drive` high and `cas_out` = i, and returns no vector.
- R10: With `role_slave` high and not single, the controller acts on `inta` only when `cas_in` equals bits 2:0 of its cascade word. Otherwise its state and `int_out` are unchanged.
- R11: Mode word bit 4 enables nested mode. In that mode a new request on an in-service cascade input raises `int_out` again. Without it, that request waits.
- R12: An acknowledge with no qualifying request returns vector {base, 7} and sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_slave | input | 1 | 1 selects the slave role in cascade operation |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is valid the next cycle |
| addr | input | 1 | 0 = command address, 1 = data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq_in | input | 8 | Edge-triggered interrupt inputs |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | One-cycle acknowledge pulse |
| cas_in | input | 3 | Cascade code seen by a slave |
| cas_out | output | 3 | Cascade code driven by a master |
| cas_drive | output | 1 | One-cycle pulse: master answers through the cascade bus |
| vec_valid | output | 1 | One-cycle pulse: `vec_out` holds a vector |
| vec_out | output | 8 | Returned vector |

## Verification
The bench targets several corner cases, each with the failure a wrong design would show:
- Simultaneous requests and a request below an active in-service bit: a broken priority compare returns the wrong vector first, or interrupts an active handler.
- Rotated priority with input 1 lowest: a design that ignores the setting still lets input 0 beat input 3.
- A second request on the in-service cascade input, with and without nested mode: a design that mishandles the mode either deadlocks the slave or re-raises when it must not.
- A slave that sees a foreign cascade code, a spurious acknowledge, and a request held across reconfiguration: a careless design answers anyway, sets an in-service bit, or raises a phantom interrupt.

// File: rtl/irq_ctrl8_pkg.sv
package irq_ctrl8_pkg;
  typedef enum logic [2:0] {
    CFG_NONE, CFG_BASE, CFG_CASC, CFG_MODE, CFG_RUN
  } cfg_state_e;

  // command sub-opcodes carried in bits 7:5 of a non-setup command
  localparam logic [2:0] OP_EOI_ANY = 3'b001;
  localparam logic [2:0] OP_SET_LOW = 3'b110;
endpackage

// File: rtl/irq_init_seq.sv
module irq_init_seq
  import irq_ctrl8_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             want_mode,
  input  logic             single_req,
  input  logic             data_we,
  input  logic [DW-1:0]    data_in,
  output logic             busy,
  output logic             ready,
  output logic [DW-IW-1:0] base_hi,
  output logic [DW-1:0]    casc_word,
  output logic             single_mode,
  output logic             nest_mode
);
  localparam int NEST_BIT = 4;

  cfg_state_e st_q;
  logic       need_mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= CFG_NONE;
      base_hi     <= '0;
      casc_word   <= '0;
      single_mode <= 1'b0;
      need_mode_q <= 1'b0;
      nest_mode   <= 1'b0;
    end else if (start) begin
      st_q        <= CFG_BASE;
      single_mode <= single_req;
      need_mode_q <= want_mode;
      nest_mode   <= 1'b0;
    end else if (data_we) begin
      case (st_q)
        CFG_BASE: begin
          base_hi <= data_in[DW-1:IW];
          if (!single_mode)     st_q <= CFG_CASC;
          else if (need_mode_q) st_q <= CFG_MODE;
          else                  st_q <= CFG_RUN;
        end
        CFG_CASC: begin
          casc_word <= data_in;
          st_q      <= need_mode_q ? CFG_MODE : CFG_RUN;
        end
        CFG_MODE: begin
          nest_mode <= data_in[NEST_BIT];
          st_q      <= CFG_RUN;
        end
        default: ;
      endcase
    end
  end

  assign busy  = (st_q == CFG_BASE) || (st_q == CFG_CASC) || (st_q == CFG_MODE);
  assign ready = (st_q == CFG_RUN);
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    // history flop needs no reset: it only tracks the input
    always_ff @(posedge clk) prev_q[g] <= lvl[g];
    assign rise[g] = lvl[g] & ~prev_q[g];
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] lowest,
  output logic          found,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] pos;

  // walk from lowest rank to highest so the highest-ranked hit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    pos   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      pos = lowest + IW'(1) + IW'(k);
      if (vec[pos]) begin
        found = 1'b1;
        idx   = pos;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
  import irq_ctrl8_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int DW   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      role_slave,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic                      addr,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  input  logic [N_IN-1:0]           irq_in,
  output logic                      int_out,
  input  logic                      inta,
  input  logic [$clog2(N_IN)-1:0]   cas_in,
  output logic [$clog2(N_IN)-1:0]   cas_out,
  output logic                      cas_drive,
  output logic                      vec_valid,
  output logic [DW-1:0]             vec_out
);
  localparam int IW = $clog2(N_IN);
  localparam logic [IW-1:0] LOW_DEFAULT = IW'(N_IN - 1);

  logic [N_IN-1:0] irr_q, isr_q, imr_q;
  logic [IW-1:0]   low_q;
  logic            rd_isr_q;

  // command decode
  logic cmd_wr, dat_wr, setup_cmd, sel_cmd, op_cmd, eoi_cmd, setlow_cmd;
  assign cmd_wr     = wr_en && !addr;
  assign dat_wr     = wr_en && addr;
  assign setup_cmd  = cmd_wr && wdata[4];
  assign sel_cmd    = cmd_wr && !wdata[4] && wdata[3];
  assign op_cmd     = cmd_wr && !wdata[4] && !wdata[3];
  assign eoi_cmd    = op_cmd && (wdata[7:5] == OP_EOI_ANY);
  assign setlow_cmd = op_cmd && (wdata[7:5] == OP_SET_LOW);

  logic            cfg_busy, cfg_ready, single_mode, nest_mode;
  logic [DW-IW-1:0] base_hi;
  logic [DW-1:0]   casc_word;

  irq_init_seq #(.DW(DW), .IW(IW)) u_init (
    .clk        (clk),
    .rst        (rst),
    .start      (setup_cmd),
    .want_mode  (wdata[0]),
    .single_req (wdata[1]),
    .data_we    (dat_wr),
    .data_in    (wdata),
    .busy       (cfg_busy),
    .ready      (cfg_ready),
    .base_hi    (base_hi),
    .casc_word  (casc_word),
    .single_mode(single_mode),
    .nest_mode  (nest_mode)
  );

  logic [N_IN-1:0] rise;
  irq_edge_detect #(.N(N_IN)) u_edge (
    .clk (clk),
    .lvl (irq_in),
    .rise(rise)
  );

  logic          w_found, h_found;
  logic [IW-1:0] w_idx, h_idx;
  logic [N_IN-1:0] req_live;
  assign req_live = irr_q & ~imr_q;

  irq_prio_pick #(.N(N_IN), .IW(IW)) u_pick_req (
    .vec(req_live), .lowest(low_q), .found(w_found), .idx(w_idx)
  );
  irq_prio_pick #(.N(N_IN), .IW(IW)) u_pick_isr (
    .vec(isr_q), .lowest(low_q), .found(h_found), .idx(h_idx)
  );

  // rank 0 is the highest priority
  logic [IW-1:0] w_rank, h_rank;
  assign w_rank = w_idx - low_q - IW'(1);
  assign h_rank = h_idx - low_q - IW'(1);

  logic cas_slot, pending, slave_eff, addressed, take, grant;
  assign cas_slot  = !single_mode && !role_slave && casc_word[w_idx];
  assign pending   = cfg_ready && w_found &&
                     (!h_found || (w_rank < h_rank) ||
                      (nest_mode && cas_slot && (w_idx == h_idx)));
  assign slave_eff = role_slave && !single_mode;
  assign addressed = !slave_eff || (cas_in == casc_word[IW-1:0]);
  assign take      = inta && cfg_ready && addressed;
  assign grant     = take && pending;

  logic [N_IN-1:0] ack_set, eoi_clr;
  assign ack_set = grant ? (N_IN'(1) << w_idx) : '0;
  assign eoi_clr = (eoi_cmd && h_found) ? (N_IN'(1) << h_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q     <= '0;
      isr_q     <= '0;
      imr_q     <= '1;
      low_q     <= LOW_DEFAULT;
      rd_isr_q  <= 1'b0;
      int_out   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
      cas_drive <= 1'b0;
      cas_out   <= '0;
      rdata     <= '0;
    end else begin
      vec_valid <= 1'b0;
      cas_drive <= 1'b0;
      int_out   <= pending && !take;
      if (setup_cmd) begin
        irr_q    <= '0;
        isr_q    <= '0;
        imr_q    <= '1;
        low_q    <= LOW_DEFAULT;
        rd_isr_q <= 1'b0;
      end else begin
        irr_q <= (irr_q | rise) & ~ack_set;
        isr_q <= (isr_q & ~eoi_clr) | ack_set;
        if (dat_wr && !cfg_busy) imr_q <= wdata[N_IN-1:0];
        if (setlow_cmd) low_q <= wdata[IW-1:0];
        if (sel_cmd && wdata[1]) rd_isr_q <= wdata[0];
        if (take) begin
          if (pending && cas_slot) begin
            cas_drive <= 1'b1;
            cas_out   <= w_idx;
          end else if (pending) begin
            vec_valid <= 1'b1;
            vec_out   <= {base_hi, w_idx};
          end else begin
            vec_valid <= 1'b1;
            vec_out   <= {base_hi, LOW_DEFAULT};
          end
        end
      end
      if (rd_en) begin
        if (addr)          rdata <= DW'(imr_q);
        else if (rd_isr_q) rdata <= DW'(isr_q);
        else               rdata <= DW'(irr_q);
      end
    end
  end
endmodule

// File: rtl/irq_ctrl8_chk.sv
module irq_ctrl8_chk #(
  parameter int N_IN = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            inta,
  input logic            int_out,
  input logic            vec_valid,
  input logic            cas_drive,
  input logic            cfg_ready,
  input logic [N_IN-1:0] isr_q
);
  p_quiet_until_cfg_r1: assert property (@(posedge clk) disable iff (rst)
    !cfg_ready |=> !int_out);

  p_isr_needs_ack_r8: assert property (@(posedge clk) disable iff (rst)
    ((isr_q & ~$past(isr_q)) != '0) |-> $past(inta));

  p_one_grant_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(isr_q & ~$past(isr_q)) <= 1);

  p_vec_after_ack_r8: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(inta));

  p_cas_excl_r9: assert property (@(posedge clk) disable iff (rst)
    cas_drive |-> (!vec_valid && $past(inta)));
endmodule

bind irq_ctrl8 irq_ctrl8_chk #(.N_IN(N_IN)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .inta     (inta),
  .int_out  (int_out),
  .vec_valid(vec_valid),
  .cas_drive(cas_drive),
  .cfg_ready(cfg_ready),
  .isr_q    (isr_q)
);

// File: tb/irq_ctrl8_tb_top.sv
module irq_ctrl8_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, role_slave, wr_en, rd_en, addr, inta;
  logic [7:0] wdata, rdata, irq_in, vec_out;
  logic [2:0] cas_in, cas_out;
  logic       int_out, cas_drive, vec_valid;

  irq_ctrl8 dut_i (
    .clk(clk), .rst(rst), .role_slave(role_slave), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .int_out(int_out),
    .inta(inta), .cas_in(cas_in), .cas_out(cas_out), .cas_drive(cas_drive),
    .vec_valid(vec_valid), .vec_out(vec_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;
  logic [8:0] exp_q[$];   // {is_cascade, value}

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares every answer against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && (vec_valid || cas_drive)) begin
      logic [8:0] got;
      got = cas_drive ? {1'b1, 5'd0, cas_out} : {1'b0, vec_out};
      if (exp_q.size() == 0) check("R8 unexpected answer", got, 9'h1ff);
      else check("R8/R9 answer", got, exp_q.pop_front());
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input logic [7:0] bits);
    @(negedge clk); irq_in = irq_in | bits;
    repeat (2) @(negedge clk);
    irq_in = irq_in & ~bits;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic ack(input bit expect_it, input logic [8:0] item);
    if (expect_it) exp_q.push_back(item);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    settle();
  endtask

  task automatic rd_isr(input string req, input logic [7:0] exp);
    logic [7:0] v;
    wr(1'b0, 8'h0B);
    rd(1'b0, v);
    check(req, {1'b0, v}, {1'b0, exp});
  endtask

  task automatic setup4(input logic [7:0] base, input logic [7:0] cw, input logic [7:0] mode);
    wr(1'b0, 8'h11); wr(1'b1, base); wr(1'b1, cw); wr(1'b1, mode);
    wr(1'b1, 8'h00);
    settle();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst = 1'b1; role_slave = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 1'b0;
    inta = 1'b0; wdata = '0; irq_in = '0; cas_in = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 int_out", {8'd0, int_out}, 9'd0);
    rd(1'b1, v); check("R1 mask", {1'b0, v}, 9'h0ff);
    rd(1'b0, v); check("R1 request reg", {1'b0, v}, 9'h000);

    // R1/R4: edge before setup is cleared by setup; held level does not retrigger
    @(negedge clk); irq_in[3] = 1'b1;
    settle();
    check("R1 no int before setup", {8'd0, int_out}, 9'd0);
    setup4(8'h20, 8'h04, 8'h01);
    check("R4 held level no retrigger", {8'd0, int_out}, 9'd0);
    @(negedge clk); irq_in[3] = 1'b0;

    // R3: mask
    wr(1'b1, 8'h20);
    pulse(8'h20); settle();
    check("R3 masked request", {8'd0, int_out}, 9'd0);
    rd(1'b1, v); check("R3 mask readback", {1'b0, v}, 9'h020);
    wr(1'b1, 8'h00); settle();
    check("R3 unmasked request", {8'd0, int_out}, 9'd1);
    wr(1'b0, 8'h0A); rd(1'b0, v);
    check("R4 request readback", {1'b0, v}, 9'h020);
    ack(1'b1, 9'h025);
    check("R8 int drops after ack", {8'd0, int_out}, 9'd0);
    rd_isr("R8 in-service set", 8'h20);
    wr(1'b0, 8'h20);
    rd_isr("R7 eoi clears", 8'h00);

    // R5: fixed priority and blocking by in-service
    pulse(8'h42); settle();
    ack(1'b1, 9'h021);
    check("R5 lower blocked by in-service", {8'd0, int_out}, 9'd0);
    wr(1'b0, 8'h20); settle();
    check("R5 raised after eoi", {8'd0, int_out}, 9'd1);
    ack(1'b1, 9'h026);
    wr(1'b0, 8'h20);

    // R5/R7: nesting, eoi clears only the highest
    pulse(8'h10); settle(); ack(1'b1, 9'h024);
    pulse(8'h01); settle();
    check("R5 higher nests", {8'd0, int_out}, 9'd1);
    ack(1'b1, 9'h020);
    rd_isr("R5 two in service", 8'h11);
    wr(1'b0, 8'h20);
    rd_isr("R7 highest cleared only", 8'h10);
    wr(1'b0, 8'h20);
    rd_isr("R7 all clear", 8'h00);

    // R6: input 1 lowest
    wr(1'b0, 8'hC1);
    pulse(8'h09); settle();
    ack(1'b1, 9'h023);
    check("R6 input 0 below input 3", {8'd0, int_out}, 9'd0);
    wr(1'b0, 8'h20); settle();
    ack(1'b1, 9'h020);
    wr(1'b0, 8'h20);

    // R9/R11: cascade input without nested mode
    pulse(8'h04); settle();
    ack(1'b1, 9'h102);
    rd_isr("R9 cascade in service", 8'h04);
    pulse(8'h04); settle();
    check("R11 no nest when off", {8'd0, int_out}, 9'd0);
    wr(1'b0, 8'h20); settle();
    ack(1'b1, 9'h102);
    wr(1'b0, 8'h20);

    // R12: spurious
    check("R12 idle", {8'd0, int_out}, 9'd0);
    ack(1'b1, 9'h027);
    rd_isr("R12 no in-service", 8'h00);

    // R11: nested mode on
    setup4(8'h20, 8'h04, 8'h10);
    pulse(8'h04); settle();
    ack(1'b1, 9'h102);
    pulse(8'h04); settle();
    check("R11 cascade re-raises", {8'd0, int_out}, 9'd1);
    ack(1'b1, 9'h102);
    rd_isr("R11 in service", 8'h04);
    wr(1'b0, 8'h20);

    // R2: single mode, no mode word; input 2 is an ordinary input
    wr(1'b0, 8'h12); wr(1'b1, 8'h40); wr(1'b1, 8'h00);
    rd(1'b1, v); check("R2 mask after short setup", {1'b0, v}, 9'h000);
    pulse(8'h04); settle();
    ack(1'b1, 9'h042);
    wr(1'b0, 8'h20);

    // R10: slave role
    role_slave = 1'b1;
    setup4(8'h70, 8'h02, 8'h01);
    pulse(8'h20); settle();
    cas_in = 3'd3;
    ack(1'b0, 9'h000);
    check("R10 foreign code keeps int", {8'd0, int_out}, 9'd1);
    rd_isr("R10 foreign code no grant", 8'h00);
    cas_in = 3'd2;
    ack(1'b1, 9'h075);
    rd_isr("R10 own code grants", 8'h20);

    settle();
    check("R8 scoreboard drained", 9'(exp_q.size()), 9'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule